// File: doc/BRIEF.md
# Single-Wire Climate Sensor Responder

This block stands in for the sensor end of a single-wire humidity and temperature link, so that a host controller can be exercised against it. The data line is open-drain. The block sees it as a sampled input, `line_in`, and pulls it down through `drive_low`. Every timing counts periods of a 1 µs enable, `tick_1us`, while the logic itself runs on the faster system clock.

After reset the block stays silent for a blanking interval. It then waits for the host to hold the line low for long enough and release it. When that happens it latches the humidity and temperature integer inputs into a frame register and pauses for a short turnaround. It then answers with a presence pulse pair and sends a 40-bit frame as pulse-width-coded bits: a fixed low lead-in, then a short high phase for a 0 or a long high phase for a 1. A closing low pulse ends the exchange, and the block goes back to waiting for the next start request.

Top module: `thermo_hygro_responder`

## Requirements
- R1: While reset is asserted and right after it, `drive_low` is 0, so the line is released.
- R2: For the first `BLANK_US` ticks after reset, a valid start request gets no response: `drive_low` stays 0.
- R3: A start request is a host low phase of at least `START_MIN_US` ticks followed by a release. A shorter low phase is discarded, and no response follows it.
- R4: `TURN_US` ticks after the release, the block pulls low for `PRES_LOW_US` ticks and then releases for `PRES_HIGH_US` ticks.
- R5: Each bit is `BIT_LOW_US` ticks low, then released for `ZERO_HIGH_US` ticks when the bit is 0 or `ONE_HIGH_US` ticks when the bit is 1.
- R6: The frame is 40 bits, most significant bit first. Byte 4 (sent first) is the humidity integer, byte 3 is humidity fraction, byte 2 is the temperature integer, byte 1 is temperature fraction, and byte 0 (sent last) is the checksum.
- R7: Both fraction bytes are always sent as 8'h00.
- R8: The checksum is the sum of the four data bytes, truncated to 8 bits: (hum_int + temp_int) mod 256.
- R9: After bit 0 the block pulls low for `END_LOW_US` ticks, then releases the line and answers a later start request in the same way.
- R10: The measurement inputs are captured when the start request is recognised. Changes to them during the exchange do not alter the frame being sent.
- R11: All durations advance only on cycles where `tick_1us` is 1. `drive_low` changes only on the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-cycle enable, once per microsecond |
| line_in | input | 1 | Sampled level of the shared data line |
| hum_int | input | 8 | Humidity integer reading |
| temp_int | input | 8 | Temperature integer reading |
| drive_low | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest situation to reach from the ports is an input change in the middle of an exchange, after capture but while bits are still going out. The bench changes both measurement inputs to new random values a few cycles after each release, then checks the decoded frame against the values applied before the release. The blanking window and the too-short start request are reached with directed host pulses, one just above and one just below the minimum low time. The random exchanges and the values 0 and 255 cover the checksum wrap.

// File: rtl/thermo_hygro_responder.sv
module thermo_hygro_responder #(
  parameter int BLANK_US     = 1_000_000,
  parameter int START_MIN_US = 18_000,
  parameter int TURN_US      = 30,
  parameter int PRES_LOW_US  = 80,
  parameter int PRES_HIGH_US = 80,
  parameter int BIT_LOW_US   = 50,
  parameter int ZERO_HIGH_US = 26,
  parameter int ONE_HIGH_US  = 70,
  parameter int END_LOW_US   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1us,
  input  logic       line_in,
  input  logic [7:0] hum_int,
  input  logic [7:0] temp_int,
  output logic       drive_low
);

  localparam int NBITS = 40;
  localparam int CMAX  = (BLANK_US > START_MIN_US) ? BLANK_US : START_MIN_US;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int BW    = $clog2(NBITS);

  typedef enum logic [3:0] {
    S_BLANK, S_IDLE, S_HLOW, S_TURN, S_PLO, S_PHI, S_BLO, S_BHI, S_ELO
  } st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   dur;
  logic [NBITS-1:0] frame;
  logic [BW-1:0]   bidx;
  logic            sync1, line_s;
  logic            done_ph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sync1, line_s} <= 2'b11;
    else        {sync1, line_s} <= {line_in, sync1};

  always_comb
    case (st)
      S_BLANK: dur = CW'(BLANK_US);
      S_TURN:  dur = CW'(TURN_US);
      S_PLO:   dur = CW'(PRES_LOW_US);
      S_PHI:   dur = CW'(PRES_HIGH_US);
      S_BLO:   dur = CW'(BIT_LOW_US);
      S_BHI:   dur = frame[NBITS-1] ? CW'(ONE_HIGH_US) : CW'(ZERO_HIGH_US);
      S_ELO:   dur = CW'(END_LOW_US);
      default: dur = '1;
    endcase

  assign done_ph   = tick_1us && (cnt == dur - CW'(1));
  assign drive_low = (st == S_PLO) || (st == S_BLO) || (st == S_ELO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_BLANK;
      cnt   <= '0;
      frame <= '0;
      bidx  <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (!line_s) begin
            st  <= S_HLOW;
            cnt <= '0;
          end
        S_HLOW:
          if (line_s) begin
            cnt <= '0;
            if (cnt >= CW'(START_MIN_US)) begin
              st    <= S_TURN;
              frame <= {hum_int, 8'h00, temp_int, 8'h00, hum_int + temp_int};
              bidx  <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else if (tick_1us && cnt < CW'(START_MIN_US)) begin
            cnt <= cnt + CW'(1);
          end
        default:
          if (done_ph) begin
            cnt <= '0;
            case (st)
              S_BLANK: st <= S_IDLE;
              S_TURN:  st <= S_PLO;
              S_PLO:   st <= S_PHI;
              S_PHI:   st <= S_BLO;
              S_BLO:   st <= S_BHI;
              S_BHI: begin
                frame <= {frame[NBITS-2:0], 1'b0};
                bidx  <= bidx + BW'(1);
                st    <= (bidx == BW'(NBITS - 1)) ? S_ELO : S_BLO;
              end
              default: st <= S_IDLE;
            endcase
          end else if (tick_1us) begin
            cnt <= cnt + CW'(1);
          end
      endcase
    end
  end

endmodule

module thermo_hygro_responder_chk #(
  parameter int BLANK_US    = 1_000_000,
  parameter int PRES_LOW_US = 80,
  parameter int BIT_LOW_US  = 50,
  parameter int END_LOW_US  = 50
) (
  input logic clk,
  input logic rst_n,
  input logic tick_1us,
  input logic drive_low
);

  int blank_cnt;
  int lo_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      blank_cnt <= 0;
      lo_cnt    <= 0;
    end else begin
      if (tick_1us && blank_cnt < BLANK_US) blank_cnt <= blank_cnt + 1;
      if (!drive_low)    lo_cnt <= 0;
      else if (tick_1us) lo_cnt <= lo_cnt + 1;
    end

  // R1
  always_comb
    if (!rst_n) reset_release_chk: assert (!drive_low);

  // R2
  blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_cnt < BLANK_US) |-> !drive_low);

  // R11
  tick_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_low != $past(drive_low)) |-> $past(tick_1us));

  // R5
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> (lo_cnt == PRES_LOW_US || lo_cnt == BIT_LOW_US || lo_cnt == END_LOW_US));

endmodule

bind thermo_hygro_responder thermo_hygro_responder_chk #(
  .BLANK_US(BLANK_US), .PRES_LOW_US(PRES_LOW_US),
  .BIT_LOW_US(BIT_LOW_US), .END_LOW_US(END_LOW_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .drive_low(drive_low)
);

// File: tb/thermo_hygro_responder_bench.sv
module thermo_hygro_responder_bench;
  localparam int BLANK = 600, SMIN = 200, TURN = 30;
  localparam int PLO = 80, PHI = 80, BLO = 50, ZHI = 26, OHI = 70, ELO = 50;

  logic clk = 0, rst_n = 0, tick = 0, host_pull = 0;
  logic [7:0] hum = 0, temp = 0;
  logic drive_low, line_in;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tick <= ~tick;
  assign line_in = ~(host_pull | drive_low);

  thermo_hygro_responder #(
    .BLANK_US(BLANK), .START_MIN_US(SMIN), .TURN_US(TURN),
    .PRES_LOW_US(PLO), .PRES_HIGH_US(PHI), .BIT_LOW_US(BLO),
    .ZERO_HIGH_US(ZHI), .ONE_HIGH_US(OHI), .END_LOW_US(ELO)
  ) u_thermo_hygro_responder (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick), .line_in(line_in),
    .hum_int(hum), .temp_int(temp), .drive_low(drive_low)
  );

  function automatic logic [39:0] exp_frame(input logic [7:0] h, input logic [7:0] t);
    logic [7:0] s;
    s = h + t;
    return {h, 8'h00, t, 8'h00, s};
  endfunction

  function automatic bit near(input int a, input int e);
    return (a >= e - 1) && (a <= e + 1);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic measure(input logic lvl, input int limit, output int n);
    n = 0;
    while (drive_low !== lvl && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic exchange(input int low_us, input bit expect_resp,
                          input logic [7:0] h, input logic [7:0] t);
    int n, pl, ph, bl, bh, bad_lo, bad_hi;
    logic [39:0] got, want;
    @(negedge clk);
    hum = h; temp = t;
    want = exp_frame(h, t);
    host_pull = 1;
    repeat (low_us * 2) @(negedge clk);
    host_pull = 0;
    repeat (10) @(negedge clk);
    hum = 8'($urandom); temp = 8'($urandom);
    if (!expect_resp) begin
      measure(1, 1000, n);
      check(n == 1000, "R2/R3 no response", n, 1000);
      return;
    end
    measure(1, 2000, n);
    check(near(n + 10, 2 * TURN + 3) || (n + 10 == 2 * TURN + 5), "R4/R11 turnaround", n + 10, 2 * TURN + 3);
    measure(0, 2000, pl);
    check(near(pl, 2 * PLO), "R4 presence low", pl, 2 * PLO);
    measure(1, 2000, ph);
    check(near(ph, 2 * PHI), "R4 presence high", ph, 2 * PHI);
    bad_lo = 0; bad_hi = 0; got = '0;
    for (int b = 0; b < 40; b++) begin
      measure(0, 2000, bl);
      measure(1, 2000, bh);
      if (!near(bl, 2 * BLO)) bad_lo++;
      if (!near(bh, 2 * ZHI) && !near(bh, 2 * OHI)) bad_hi++;
      got = {got[38:0], bh > 2 * 60};
    end
    check(bad_lo == 0, "R5 bit low phases", bad_lo, 0);
    check(bad_hi == 0, "R5 bit high phases", bad_hi, 0);
    check(got[31:24] == 8'h00 && got[15:8] == 8'h00, "R7 fraction bytes", {got[31:24], got[15:8]}, 0);
    check(got[7:0] == want[7:0], "R8 checksum", got[7:0], want[7:0]);
    check(got == want, "R6/R10 frame", got, want);
    measure(0, 2000, n);
    check(near(n, 2 * ELO), "R9 closing low", n, 2 * ELO);
    measure(1, 400, n);
    check(n == 400, "R9 line released", n, 400);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    repeat (4) @(negedge clk);
    check(drive_low == 1'b0, "R1 reset state", drive_low, 0);
    rst_n = 1;
    @(negedge clk);
    check(drive_low == 1'b0, "R1 after reset", drive_low, 0);
    exchange(SMIN + 5, 0, 8'h11, 8'h22);
    repeat (BLANK * 2) @(negedge clk);
    exchange(SMIN - 10, 0, 8'h33, 8'h44);
    exchange(SMIN + 5, 1, 8'h00, 8'h00);
    exchange(SMIN + 5, 1, 8'hFF, 8'hFF);
    exchange(SMIN + 5, 1, 8'hAA, 8'h55);
    for (int i = 0; i < 5; i++)
      exchange(SMIN + 5 + int'($urandom % 40), 1, 8'($urandom), 8'($urandom));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule